// File: doc/BRIEF.md
# Incremental Pulse Program-Verify Controller

This block sequences write operations on a single resistive memory cell. A program operation drives the cell toward low resistance. An erase operation drives it toward high resistance. Each operation is a loop. The controller requests one pulse from an external pulse generator, waits for the pulse to complete, then requests a separate verify read from an external read path. It judges the returned resistance code and then either stops or requests a stronger pulse.

Program pulses keep a fixed amplitude, and their width grows by about ten percent after every failed verify. Erase pulses keep a fixed width, and the magnitude of their (negative) amplitude grows in the same way. The loop ends in one of three ways:
- the cell reaches its target resistance;
- the next pulse parameter would pass its ceiling;
- a read reports a resistance so low that the cell must be considered damaged.

On every ending, a one-cycle done strobe carries a two-bit result code. A counter reports how many pulses the last operation used.

Widths are coded in nanoseconds, amplitudes in signed millivolts, and resistances in ohms.

Top module: `rram_pv_ctrl`

## Requirements
- R1: After reset, busy, done, pulse_valid and read_valid are 0, status is 2'b00 and step_cnt is 0.
- R2: A program operation issues pulses of amplitude 1000 (mV). The first pulse has width 20 (ns). After each failed verify the width p becomes p + ceil(p/10).
- R3: An erase operation issues pulses of width 100 (ns). The first pulse has amplitude -500 (mV). After each failed verify the magnitude m becomes m + ceil(m/10), and the amplitude is -m.
- R4: Each pulse is handed over when pulse_valid and pulse_ready are both 1, and it completes on pulse_ack. Only after that is a read requested, and it is handed over when read_valid and read_ready are both 1 and completes on read_ack. pulse_valid and read_valid are never 1 together. A waiting request holds its parameters stable.
- R5: A program verify succeeds when read_res <= tgt_on. An erase verify succeeds when read_res >= tgt_off. Success ends the operation with done and status 2'b01.
- R6: When a verify fails and the grown parameter would exceed its ceiling (width 1000000000 ns for program, magnitude 10000 mV for erase), the operation ends with done and status 2'b10. No pulse beyond the ceiling is issued.
- R7: A read_res below 30 ends the operation with done and status 2'b11, and no further pulse is requested. This check takes priority over success. A value of exactly 30 is not damage.
- R8: step_cnt counts the pulses handed over in the current operation. It is cleared when an operation starts and holds its value after the operation ends.
- R9: done is high for exactly one cycle per operation. status shows the result code only in that cycle and is 2'b00 in every other cycle.
- R10: Start requests are ignored while busy. If start_pgm and start_ers are raised in the same cycle, a program operation is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_pgm | input | 1 | Start a program (toward low resistance) operation |
| start_ers | input | 1 | Start an erase (toward high resistance) operation |
| tgt_on | input | RES_W | On-state target resistance code |
| tgt_off | input | RES_W | Off-state target resistance code |
| pulse_valid | output | 1 | Pulse request pending |
| pulse_ready | input | 1 | Pulse generator accepts the request |
| pulse_width | output | PAR_W | Requested pulse width (ns) |
| pulse_amp | output | AMP_W | Requested pulse amplitude, signed (mV) |
| pulse_ack | input | 1 | Pulse has been applied |
| read_valid | output | 1 | Verify read request pending |
| read_ready | input | 1 | Read path accepts the request |
| read_ack | input | 1 | Read finished, read_res valid |
| read_res | input | RES_W | Measured resistance code (ohms) |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle end-of-operation strobe |
| status | output | 2 | 01 success, 10 ceiling reached, 11 damaged, 00 otherwise |
| step_cnt | output | STEP_W | Pulses used by the current or last operation |

## Verification
In a program operation, one verify read can meet both the damage rule and the success rule. Any resistance below 30 ohms is also below the on-state target. The bench drives a behavioural cell that returns 25 ohms after the second program pulse, and it checks that done arrives with status 2'b11 and not 2'b01, after exactly two pulses. It then watches that no pulse request follows. Reads of 29 and of exactly 30 ohms in erase operations show that the damage decision switches at the stated boundary.

// File: rtl/pv_pkg.sv
package pv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULSE_REQ,
        ST_PULSE_WAIT,
        ST_READ_REQ,
        ST_READ_WAIT
    } pv_state_e;

    typedef enum logic [1:0] {
        RES_NONE    = 2'b00,
        RES_OK      = 2'b01,
        RES_LIMIT   = 2'b10,
        RES_DAMAGED = 2'b11
    } pv_result_e;

    typedef enum logic [1:0] {
        VD_RETRY,
        VD_OK,
        VD_LIMIT,
        VD_DAMAGED
    } pv_verdict_e;

    function automatic pv_result_e verdict_to_result(pv_verdict_e v);
        case (v)
            VD_OK:      return RES_OK;
            VD_LIMIT:   return RES_LIMIT;
            VD_DAMAGED: return RES_DAMAGED;
            default:    return RES_NONE;
        endcase
    endfunction

endpackage

// File: rtl/pv_grow.sv
module pv_grow #(
    parameter int PAR_W = 32
) (
    input  logic [PAR_W-1:0] cur,
    output logic [PAR_W:0]   nxt
);
    localparam int EXT_W = PAR_W + 1;

    logic [EXT_W-1:0] cur_x;
    logic [EXT_W-1:0] inc;

    always_comb begin
        cur_x = {1'b0, cur};
        inc   = (cur_x + EXT_W'(9)) / EXT_W'(10);
        nxt   = cur_x + inc;
    end
endmodule

// File: rtl/pv_judge.sv
module pv_judge
    import pv_pkg::*;
#(
    parameter int RES_W  = 20,
    parameter int PAR_W  = 32,
    parameter int DMG_TH = 30
) (
    input  logic             is_pgm,
    input  logic [RES_W-1:0] res,
    input  logic [RES_W-1:0] tgt_on,
    input  logic [RES_W-1:0] tgt_off,
    input  logic [PAR_W:0]   nxt,
    input  logic [PAR_W-1:0] ceiling,
    output pv_verdict_e      verdict
);
    logic damaged, reached, over;

    always_comb begin
        damaged = res < RES_W'(DMG_TH);
        reached = is_pgm ? (res <= tgt_on) : (res >= tgt_off);
        over    = nxt > {1'b0, ceiling};
        if (damaged)      verdict = VD_DAMAGED;
        else if (reached) verdict = VD_OK;
        else if (over)    verdict = VD_LIMIT;
        else              verdict = VD_RETRY;
    end
endmodule

// File: rtl/rram_pv_ctrl.sv
module rram_pv_ctrl
    import pv_pkg::*;
#(
    parameter int          RES_W         = 20,
    parameter int          PAR_W         = 32,
    parameter int          AMP_W         = 16,
    parameter int          STEP_W        = 8,
    parameter int unsigned PGM_AMP       = 1000,
    parameter int unsigned PW_START      = 20,
    parameter int unsigned PW_MAX        = 1_000_000_000,
    parameter int unsigned ERS_WIDTH     = 100,
    parameter int unsigned ERS_AMP_START = 500,
    parameter int unsigned ERS_AMP_END   = 10000,
    parameter int          DMG_TH        = 30
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_pgm,
    input  logic                    start_ers,
    input  logic [RES_W-1:0]        tgt_on,
    input  logic [RES_W-1:0]        tgt_off,
    output logic                    pulse_valid,
    input  logic                    pulse_ready,
    output logic [PAR_W-1:0]        pulse_width,
    output logic signed [AMP_W-1:0] pulse_amp,
    input  logic                    pulse_ack,
    output logic                    read_valid,
    input  logic                    read_ready,
    input  logic                    read_ack,
    input  logic [RES_W-1:0]        read_res,
    output logic                    busy,
    output logic                    done,
    output logic [1:0]              status,
    output logic [STEP_W-1:0]       step_cnt
);
    localparam logic [PAR_W-1:0] PW_START_C  = PAR_W'(PW_START);
    localparam logic [PAR_W-1:0] PW_MAX_C    = PAR_W'(PW_MAX);
    localparam logic [PAR_W-1:0] EA_START_C  = PAR_W'(ERS_AMP_START);
    localparam logic [PAR_W-1:0] EA_END_C    = PAR_W'(ERS_AMP_END);
    localparam logic [PAR_W-1:0] ERS_WIDTH_C = PAR_W'(ERS_WIDTH);
    localparam logic [AMP_W-1:0] PGM_AMP_C   = AMP_W'(PGM_AMP);

    pv_state_e          state;
    logic               is_pgm;
    logic [PAR_W-1:0]   cur;
    logic [PAR_W:0]     nxt;
    logic [PAR_W-1:0]   ceiling;
    pv_verdict_e        verdict;
    pv_result_e         result_q;

    pv_grow #(.PAR_W(PAR_W)) u_grow (
        .cur (cur),
        .nxt (nxt)
    );

    assign ceiling = is_pgm ? PW_MAX_C : EA_END_C;

    pv_judge #(.RES_W(RES_W), .PAR_W(PAR_W), .DMG_TH(DMG_TH)) u_judge (
        .is_pgm  (is_pgm),
        .res     (read_res),
        .tgt_on  (tgt_on),
        .tgt_off (tgt_off),
        .nxt     (nxt),
        .ceiling (ceiling),
        .verdict (verdict)
    );

    assign pulse_valid = (state == ST_PULSE_REQ);
    assign read_valid  = (state == ST_READ_REQ);
    assign busy        = (state != ST_IDLE);
    assign pulse_width = is_pgm ? cur : ERS_WIDTH_C;
    assign pulse_amp   = is_pgm ? PGM_AMP_C : (AMP_W'(0) - cur[AMP_W-1:0]);
    assign status      = result_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            is_pgm   <= 1'b0;
            cur      <= '0;
            step_cnt <= '0;
            done     <= 1'b0;
            result_q <= RES_NONE;
        end else begin
            done     <= 1'b0;
            result_q <= RES_NONE;
            case (state)
                ST_IDLE: begin
                    if (start_pgm || start_ers) begin
                        is_pgm   <= start_pgm;
                        cur      <= start_pgm ? PW_START_C : EA_START_C;
                        step_cnt <= '0;
                        state    <= ST_PULSE_REQ;
                    end
                end
                ST_PULSE_REQ: begin
                    if (pulse_ready) begin
                        step_cnt <= step_cnt + 1'b1;
                        state    <= ST_PULSE_WAIT;
                    end
                end
                ST_PULSE_WAIT: begin
                    if (pulse_ack) state <= ST_READ_REQ;
                end
                ST_READ_REQ: begin
                    if (read_ready) state <= ST_READ_WAIT;
                end
                ST_READ_WAIT: begin
                    if (read_ack) begin
                        if (verdict == VD_RETRY) begin
                            cur   <= nxt[PAR_W-1:0];
                            state <= ST_PULSE_REQ;
                        end else begin
                            done     <= 1'b1;
                            result_q <= verdict_to_result(verdict);
                            state    <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Handshake discipline
    assert_no_overlap_R4: assert property (@(posedge clk) disable iff (rst)
        !(pulse_valid && read_valid));

    assert_hold_request_R4: assert property (@(posedge clk) disable iff (rst)
        (pulse_valid && !pulse_ready) |=> (pulse_valid && $stable(pulse_width) && $stable(pulse_amp)));

    // Growth and ceiling
    assert_param_grows_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_READ_WAIT && read_ack && verdict == VD_RETRY) |=> (cur > $past(cur)));

    assert_ceiling_R6: assert property (@(posedge clk) disable iff (rst)
        pulse_valid |-> (is_pgm ? (pulse_width <= PW_MAX_C) : (cur <= EA_END_C)));

    // Damage stop
    assert_damage_stop_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_READ_WAIT && read_ack && read_res < RES_W'(DMG_TH))
        |=> (done && status == 2'b11 && !pulse_valid));

    // Result strobe
    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_status_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !done |-> (status == 2'b00));

    // Start while busy
    assert_mode_locked_R10: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(is_pgm));

endmodule

// File: tb/rram_pv_ctrl_tb.sv
module rram_pv_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int RES_W = 20, PAR_W = 32, AMP_W = 16, STEP_W = 8;
    localparam int TGT_ON = 700, TGT_OFF = 12000;
    localparam int NEVER = 100000;

    localparam int VEC_N = 8;
    // op: 1 program, 0 erase; exp steps 0 means "count to the ceiling"
    localparam int V_OP   [VEC_N] = '{1, 1, 0, 0, 1, 1, 0, 0};
    localparam int V_NSW  [VEC_N] = '{1, 5, 3, NEVER, NEVER, 2, 4, 1};
    localparam int V_RBEF [VEC_N] = '{15000, 15000, 600, 600, 15000, 15000, 600, 600};
    localparam int V_RAFT [VEC_N] = '{650, 700, 12000, 600, 15000, 25, 29, 30};
    localparam int V_ST   [VEC_N] = '{1, 1, 1, 2, 2, 3, 3, 2};
    localparam int V_STEP [VEC_N] = '{1, 5, 3, 0, 0, 2, 4, 0};

    logic clk = 0, rst = 1;
    logic start_pgm = 0, start_ers = 0;
    logic [RES_W-1:0] tgt_on = RES_W'(TGT_ON), tgt_off = RES_W'(TGT_OFF);
    logic pulse_valid, pulse_ready = 0, pulse_ack = 0;
    logic [PAR_W-1:0] pulse_width;
    logic signed [AMP_W-1:0] pulse_amp;
    logic read_valid, read_ready = 0, read_ack = 0;
    logic [RES_W-1:0] read_res = '0;
    logic busy, done;
    logic [1:0] status;
    logic [STEP_W-1:0] step_cnt;

    int n_tests = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rram_pv_ctrl dut_i (
        .clk(clk), .rst(rst), .start_pgm(start_pgm), .start_ers(start_ers),
        .tgt_on(tgt_on), .tgt_off(tgt_off),
        .pulse_valid(pulse_valid), .pulse_ready(pulse_ready),
        .pulse_width(pulse_width), .pulse_amp(pulse_amp), .pulse_ack(pulse_ack),
        .read_valid(read_valid), .read_ready(read_ready), .read_ack(read_ack),
        .read_res(read_res), .busy(busy), .done(done), .status(status),
        .step_cnt(step_cnt)
    );

    function automatic longint grow(longint p);
        return p + (p + 9) / 10;
    endfunction

    function automatic int steps_to_ceiling(longint start, longint ceil_v);
        longint p = start;
        int n = 1;
        while (grow(p) <= ceil_v) begin
            p = grow(p);
            n++;
        end
        return n;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Behavioural cell plus pulse and read responders for one operation
    task automatic run_op(input bit pgm, input int nsw, input int rbef, input int raft,
                          input bit both, input bit poke,
                          output int st, output int steps, output bit params_ok,
                          output bit overlap);
        longint par;
        int k = 0;
        int guard = 0;
        params_ok = 1;
        overlap = 0;
        st = -1;
        steps = -1;
        par = pgm ? 20 : 500;
        @(negedge clk);
        start_pgm = pgm | both;
        start_ers = !pgm | both;
        @(negedge clk);
        start_pgm = 0;
        start_ers = 0;
        while (guard < 20000) begin
            guard++;
            if (pulse_valid && read_valid) overlap = 1;
            if (done) begin
                st = int'(status);
                steps = int'(step_cnt);
                break;
            end else if (pulse_valid) begin
                k++;
                if (k > 1) par = grow(par);
                if (pgm) begin
                    if (longint'(pulse_width) != par || int'(pulse_amp) != 1000) params_ok = 0;
                end else begin
                    if (longint'(pulse_width) != 100 || longint'(pulse_amp) != -par) params_ok = 0;
                end
                pulse_ready = 1;
                if (poke && k == 2) begin
                    start_pgm = !pgm;
                    start_ers = pgm;
                end
                @(negedge clk);
                pulse_ready = 0;
                start_pgm = 0;
                start_ers = 0;
                if (read_valid) overlap = 1;
                pulse_ack = 1;
                @(negedge clk);
                pulse_ack = 0;
            end else if (read_valid) begin
                read_ready = 1;
                @(negedge clk);
                read_ready = 0;
                read_ack = 1;
                read_res = RES_W'((k >= nsw) ? raft : rbef);
                @(negedge clk);
                read_ack = 0;
            end else begin
                @(negedge clk);
            end
        end
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
                finish_run();
            end
        end
    end

    initial begin
        int st, steps, exp_steps;
        bit pok, ovl;
        int pgm_lim = steps_to_ceiling(20, 1000000000);
        int ers_lim = steps_to_ceiling(500, 10000);

        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state
        check(!busy && !done && !pulse_valid && !read_valid && status == 2'b00 && step_cnt == 0,
              "R1", "idle outputs", {busy, done, pulse_valid, read_valid, status, step_cnt}, 0);

        // Table walk: R2 R3 R5 R6 R7 R8
        for (int i = 0; i < VEC_N; i++) begin
            run_op(V_OP[i] != 0, V_NSW[i], V_RBEF[i], V_RAFT[i], 1'b0, 1'b0, st, steps, pok, ovl);
            exp_steps = (V_STEP[i] != 0) ? V_STEP[i] : (V_OP[i] != 0 ? pgm_lim : ers_lim);
            check(st == V_ST[i], V_ST[i] == 1 ? "R5" : (V_ST[i] == 2 ? "R6" : "R7"),
                  $sformatf("vector %0d status", i), st, V_ST[i]);
            check(steps == exp_steps, "R8", $sformatf("vector %0d step_cnt", i), steps, exp_steps);
            check(pok, V_OP[i] != 0 ? "R2" : "R3", $sformatf("vector %0d pulse params", i), pok, 1);
            check(!ovl, "R4", $sformatf("vector %0d overlap", i), ovl, 0);
        end

        // R9: status returns to 00 and done drops the cycle after; R8: count holds
        @(negedge clk);
        check(!done && status == 2'b00, "R9", "after done", {done, status}, 0);
        repeat (5) @(negedge clk);
        check(int'(step_cnt) == ers_lim, "R8", "step_cnt held", step_cnt, ers_lim);

        // R10: both starts together -> program
        run_op(1'b1, 3, 15000, 500, 1'b1, 1'b0, st, steps, pok, ovl);
        check(pok && st == 1 && steps == 3, "R10", "dual start runs program", st * 100 + steps, 103);

        // R10: start of the other operation while busy is ignored
        run_op(1'b1, 4, 15000, 600, 1'b0, 1'b1, st, steps, pok, ovl);
        check(pok && st == 1 && steps == 4, "R10", "program ignores erase start", st * 100 + steps, 104);
        @(negedge clk);
        check(!busy, "R10", "no operation queued", busy, 0);
        run_op(1'b0, 2, 600, 13000, 1'b0, 1'b1, st, steps, pok, ovl);
        check(pok && st == 1 && steps == 2, "R10", "erase ignores program start", st * 100 + steps, 102);

        // R7: damage during program beats success and stops pulsing
        run_op(1'b1, 1, 15000, 10, 1'b0, 1'b0, st, steps, pok, ovl);
        check(st == 3 && steps == 1, "R7", "damage priority", st * 100 + steps, 301);
        begin
            bit seen = 0;
            for (int c = 0; c < 20; c++) begin
                @(negedge clk);
                if (pulse_valid || busy) seen = 1;
            end
            check(!seen, "R7", "no pulse after damage", seen, 0);
        end

        finish_run();
    end
endmodule